// File: doc/BRIEF.md
# Two-Operand Execute Unit With Status Flags

This block performs the execute step for a 16-bit processor's two-operand instructions. Each cycle it may accept one request. A request carries the source and destination operands, a 4-bit operation code, a byte/word select and the current status word. One clock later the block presents four things:

- the result;
- a flag saying whether the destination must be written;
- the new status word;
- a valid strobe.

The supported operations fall into four groups:

- a plain move;
- binary add and subtract, with and without carry, plus a compare;
- a packed-decimal add;
- four bitwise operations and a bit test.

Subtraction is done as addition of the inverted source, with a carry-in of either one or the incoming carry. Compare and bit test update the flags but never request a write. In byte mode only the low eight bits take part. The upper byte of the result is forced to zero, and the flags are taken at bit 7.

Operand fetch, decoding and writeback are done by the surrounding pipeline. The status word is passed in on every request, and the updated copy is returned with the result.

Top module: `dop_exec_unit`

## Requirements
- R1: After reset `out_valid`, `wr_en`, `result` and `status_out` are all zero. A request with `in_valid` high at a rising edge appears at the outputs after that edge, with `out_valid` high for exactly one cycle per request. Back-to-back requests are accepted every cycle.
- R2: The operation codes are: 4 move, 5 add, 6 add with carry, 7 subtract with carry, 8 subtract, 9 compare, 10 decimal add, 11 bit test, 12 bit clear, 13 bit set, 14 exclusive or, 15 and. Move returns the source, requests a write and leaves the status word unchanged.
- R3: Add returns dst+src and add with carry returns dst+src+C. C is the carry out of the active width. V is set on signed overflow. N is the result MSB and Z means a zero result.
- R4: Subtract returns dst+NOT(src)+1 and subtract with carry returns dst+NOT(src)+C. C, V, N and Z follow the rules of R3.
- R5: Compare produces the flags of subtract. Bit test produces the flags of and. Neither of them raises `wr_en`, but `result` still carries the computed value.
- R6: Decimal add treats both operands as packed BCD digits, adding from the lowest digit upward with C as the carry-in. C becomes the decimal carry out of the top active digit. N and Z follow the result, and V is left unchanged.
- R7: And returns src AND dst. Bit clear returns NOT(src) AND dst. Bit set returns src OR dst. Exclusive or returns src XOR dst. For and and exclusive or, N and Z follow the result and C is NOT Z. And clears V, while exclusive or sets V only when both operand MSBs are one. Bit clear and bit set leave the status word unchanged.
- R8: With `byte_mode` high only bits 7:0 are processed. `result[15:8]` is zero, N is bit 7, Z looks at bits 7:0, and C and V are taken at bit 7.
- R9: In the status word, C is bit 0, Z is bit 1, N is bit 2 and V is bit 8. Every other bit, including the interrupt enable at bit 3, is copied from `status_in` unchanged.
- R10: Codes 0 to 3 are unused. They give `wr_en` low, `result` zero and `status_out` equal to `status_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code (see R2) |
| byte_mode | input | 1 | 1 = byte operation, 0 = word |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| status_in | input | 16 | Current status word |
| out_valid | output | 1 | Result present this cycle |
| result | output | 16 | Computed value |
| wr_en | output | 1 | Destination should be written |
| status_out | output | 16 | Updated status word |

## Verification
Byte-width narrowing and carry generation act together in one cycle. A byte add or subtract on operands with non-zero upper bytes must take its carry and overflow at bit 7, and at the same time keep the sum's spill into bit 8 out of the result. The bench provokes this with byte add, subtract and decimal add whose low bytes overflow while the upper bytes hold noise. It judges the outcome by a zero upper result byte together with C and V computed at eight bits by its own reference model. Randomised back-to-back requests of both widths then run through a scoreboard queue.

// File: rtl/dop_pkg.sv
package dop_pkg;
    localparam int DW = 16;
    localparam int HW = DW / 2;

    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_N = 2;
    localparam int ST_V = 8;

    localparam logic [3:0] OP_MOV  = 4'd4;
    localparam logic [3:0] OP_ADD  = 4'd5;
    localparam logic [3:0] OP_ADDC = 4'd6;
    localparam logic [3:0] OP_SUBC = 4'd7;
    localparam logic [3:0] OP_SUB  = 4'd8;
    localparam logic [3:0] OP_CMP  = 4'd9;
    localparam logic [3:0] OP_DADD = 4'd10;
    localparam logic [3:0] OP_BIT  = 4'd11;
    localparam logic [3:0] OP_BIC  = 4'd12;
    localparam logic [3:0] OP_BIS  = 4'd13;
    localparam logic [3:0] OP_XOR  = 4'd14;
    localparam logic [3:0] OP_AND  = 4'd15;

    typedef enum logic [1:0] {
        FL_KEEP,
        FL_ARITH,
        FL_DEC,
        FL_LOGIC
    } dop_flag_e;

    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [DW-1:0] res;
        logic [DW-1:0] st;
    } dop_stage_t;
endpackage

// File: rtl/dop_binadd.sv
module dop_binadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         c_o,
    output logic         v_o
);
    localparam int H = W / 2;

    logic [W:0] full_sum;
    logic [H:0] low_sum;

    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        low_sum  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]} + {{H{1'b0}}, cin_i};
        sum_o    = full_sum[W-1:0];
        if (byte_i) begin
            c_o = low_sum[H];
            v_o = (a_i[H-1] == b_i[H-1]) && (low_sum[H-1] != a_i[H-1]);
        end else begin
            c_o = full_sum[W];
            v_o = (a_i[W-1] == b_i[W-1]) && (full_sum[W-1] != a_i[W-1]);
        end
    end
endmodule

// File: rtl/dop_bcdadd.sv
module dop_bcdadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         c_o
);
    localparam int ND = W / 4;
    localparam int NH = ND / 2;

    logic [4:0] dsum;
    logic       carry;
    logic       carry_half;

    always_comb begin
        carry      = cin_i;
        carry_half = 1'b0;
        sum_o      = '0;
        dsum       = '0;
        for (int k = 0; k < ND; k++) begin
            dsum = {1'b0, a_i[4*k +: 4]} + {1'b0, b_i[4*k +: 4]} + {4'd0, carry};
            if (dsum > 5'd9) begin
                sum_o[4*k +: 4] = 4'(dsum + 5'd6);
                carry = 1'b1;
            end else begin
                sum_o[4*k +: 4] = dsum[3:0];
                carry = 1'b0;
            end
            if (k == NH - 1) begin
                carry_half = carry;
            end
        end
        c_o = byte_i ? carry_half : carry;
    end
endmodule

// File: rtl/dop_bitwise.sv
module dop_bitwise #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] clr_o,
    output logic [W-1:0] set_o,
    output logic [W-1:0] xor_o
);
    always_comb begin
        and_o = a_i & b_i;
        clr_o = a_i & ~b_i;
        set_o = a_i | b_i;
        xor_o = a_i ^ b_i;
    end
endmodule

// File: rtl/dop_exec_unit.sv
module dop_exec_unit
    import dop_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic          byte_mode,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] status_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic [DW-1:0] status_out
);
    dop_stage_t stage_d, stage_q;

    logic [DW-1:0] width_mask;
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] add_sum, dec_sum;
    logic          add_c, add_v, dec_c;
    logic [DW-1:0] bw_and, bw_clr, bw_set, bw_xor;
    logic [DW-1:0] raw_res, nar_res;
    logic          res_msb, res_zero;
    logic          do_write;
    dop_flag_e     fl_kind;
    logic          logic_v;

    dop_binadd #(.W(DW)) u_add (
        .a_i(dst), .b_i(add_b), .cin_i(add_cin), .byte_i(byte_mode),
        .sum_o(add_sum), .c_o(add_c), .v_o(add_v)
    );

    dop_bcdadd #(.W(DW)) u_dec (
        .a_i(dst), .b_i(src), .cin_i(status_in[ST_C]), .byte_i(byte_mode),
        .sum_o(dec_sum), .c_o(dec_c)
    );

    dop_bitwise #(.W(DW)) u_bw (
        .a_i(dst), .b_i(src),
        .and_o(bw_and), .clr_o(bw_clr), .set_o(bw_set), .xor_o(bw_xor)
    );

    // Operand routing for the binary adder
    always_comb begin
        add_b   = src;
        add_cin = 1'b0;
        case (op)
            OP_ADDC: add_cin = status_in[ST_C];
            OP_SUBC: begin
                add_b   = ~src;
                add_cin = status_in[ST_C];
            end
            OP_SUB, OP_CMP: begin
                add_b   = ~src;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    // Result selection, flag class and write decision
    always_comb begin
        raw_res  = '0;
        fl_kind  = FL_KEEP;
        do_write = 1'b1;
        logic_v  = 1'b0;
        case (op)
            OP_MOV: raw_res = src;
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
                raw_res = add_sum;
                fl_kind = FL_ARITH;
            end
            OP_CMP: begin
                raw_res  = add_sum;
                fl_kind  = FL_ARITH;
                do_write = 1'b0;
            end
            OP_DADD: begin
                raw_res = dec_sum;
                fl_kind = FL_DEC;
            end
            OP_AND: begin
                raw_res = bw_and;
                fl_kind = FL_LOGIC;
            end
            OP_BIT: begin
                raw_res  = bw_and;
                fl_kind  = FL_LOGIC;
                do_write = 1'b0;
            end
            OP_BIC: raw_res = bw_clr;
            OP_BIS: raw_res = bw_set;
            OP_XOR: begin
                raw_res = bw_xor;
                fl_kind = FL_LOGIC;
                logic_v = byte_mode ? (src[HW-1] & dst[HW-1]) : (src[DW-1] & dst[DW-1]);
            end
            default: do_write = 1'b0;
        endcase
    end

    // Next-state computation
    always_comb begin
        width_mask = byte_mode ? {{HW{1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
        nar_res    = raw_res & width_mask;
        res_msb    = byte_mode ? nar_res[HW-1] : nar_res[DW-1];
        res_zero   = (nar_res == '0);

        stage_d       = stage_q;
        stage_d.valid = in_valid;
        stage_d.wr    = in_valid & do_write;
        if (in_valid) begin
            stage_d.res = nar_res;
            stage_d.st  = status_in;
            case (fl_kind)
                FL_ARITH: begin
                    stage_d.st[ST_C] = add_c;
                    stage_d.st[ST_V] = add_v;
                    stage_d.st[ST_N] = res_msb;
                    stage_d.st[ST_Z] = res_zero;
                end
                FL_DEC: begin
                    stage_d.st[ST_C] = dec_c;
                    stage_d.st[ST_N] = res_msb;
                    stage_d.st[ST_Z] = res_zero;
                end
                FL_LOGIC: begin
                    stage_d.st[ST_C] = ~res_zero;
                    stage_d.st[ST_V] = logic_v;
                    stage_d.st[ST_N] = res_msb;
                    stage_d.st[ST_Z] = res_zero;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.valid;
    assign wr_en      = stage_q.wr;
    assign result     = stage_q.res;
    assign status_out = stage_q.st;

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                                  // R1
    AST_NO_WRITE_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == OP_CMP || op == OP_BIT) |=> !wr_en);                   // R5
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == OP_MOV || op == OP_BIC || op == OP_BIS)
        |=> status_out == $past(status_in));                                      // R7
    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && byte_mode |=> result[DW-1:HW] == '0);                         // R8
    AST_GIE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> status_out[3] == $past(status_in[3]));                       // R9
    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op < OP_MOV |=> !wr_en && status_out == $past(status_in));    // R10
endmodule

// File: tb/dop_exec_unit_test.sv
module dop_exec_unit_test;
    typedef struct {
        logic [15:0] res;
        logic        wr;
        logic [15:0] st;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] src = '0, dst = '0, status_in = '0;
    logic        out_valid, wr_en;
    logic [15:0] result, status_out;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    dop_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .byte_mode(byte_mode), .src(src), .dst(dst), .status_in(status_in),
        .out_valid(out_valid), .result(result), .wr_en(wr_en),
        .status_out(status_out)
    );

    function automatic exp_t model(logic [3:0] o, logic bm, logic [15:0] s,
                                   logic [15:0] d, logic [15:0] st, string tag);
        exp_t e;
        int   w = bm ? 8 : 16;
        logic [15:0] m = bm ? 16'h00FF : 16'hFFFF;
        logic [15:0] a = d & m;
        logic [15:0] b = s & m;
        logic [15:0] bb, r;
        logic [31:0] full;
        logic c = st[0];
        logic nz = 1'b1;
        int   dg, cy;
        e.st = st; e.wr = 1'b1; e.tag = tag; r = '0;
        case (o)
            4'd4: begin r = b; nz = 0; end
            4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
                bb = (o >= 4'd7) ? (~b & m) : b;
                full = 32'(a) + 32'(bb) + ((o == 4'd5) ? 32'd0 :
                       (o == 4'd6 || o == 4'd7) ? 32'(c) : 32'd1);
                r = full[15:0] & m;
                e.st[0] = full[w];
                e.st[8] = (a[w-1] == bb[w-1]) && (r[w-1] != a[w-1]);
                if (o == 4'd9) e.wr = 1'b0;
            end
            4'd10: begin
                cy = int'(c);
                for (int k = 0; k < w / 4; k++) begin
                    dg = int'((a >> (4 * k)) & 16'hF) + int'((b >> (4 * k)) & 16'hF) + cy;
                    if (dg > 9) begin dg = (dg - 10) & 15; cy = 1; end
                    else cy = 0;
                    r = r | (16'(dg) << (4 * k));
                end
                e.st[0] = cy[0];
            end
            4'd11, 4'd15: begin
                r = a & b; e.st[0] = (r != 0); e.st[8] = 1'b0;
                if (o == 4'd11) e.wr = 1'b0;
            end
            4'd12: begin r = ~b & a & m; nz = 0; end
            4'd13: begin r = a | b; nz = 0; end
            4'd14: begin
                r = a ^ b; e.st[0] = (r != 0); e.st[8] = a[w-1] & b[w-1];
            end
            default: begin r = '0; e.wr = 1'b0; nz = 0; end
        endcase
        if (nz) begin
            e.st[2] = r[w-1];
            e.st[1] = (r == 0);
        end
        e.res = r;
        return e;
    endfunction

    task automatic send(logic [3:0] o, logic bm, logic [15:0] s, logic [15:0] d,
                        logic [15:0] st, string tag);
        @(negedge clk);
        in_valid = 1'b1; op = o; byte_mode = bm; src = s; dst = d; status_in = st;
        sb.push_back(model(o, bm, s, d, st, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare every produced result against the queue head
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R1: unexpected out_valid, got res=%h", result);
                end else begin
                    e = sb.pop_front();
                    if (result !== e.res || wr_en !== e.wr || status_out !== e.st) begin
                        errors++;
                        $display("FAIL %s: got res=%h wr=%b st=%h, exp res=%h wr=%b st=%h",
                                 e.tag, result, wr_en, status_out, e.res, e.wr, e.st);
                    end
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rs, rd;
        logic [3:0]  ro;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 0 || wr_en !== 0 || result !== 0 || status_out !== 0) begin
            errors++;
            $display("FAIL R1: reset got v=%b wr=%b res=%h st=%h, exp all zero",
                     out_valid, wr_en, result, status_out);
        end
        rst_n = 1'b1;

        // R2 move
        send(4'd4, 0, 16'h1234, 16'h5555, 16'h0107, "R2");
        // R3 add / add with carry
        send(4'd5, 0, 16'h0001, 16'h7FFF, 16'h0000, "R3");
        send(4'd5, 0, 16'h0001, 16'hFFFF, 16'h0000, "R3");
        send(4'd6, 0, 16'h0003, 16'h0005, 16'h0001, "R3");
        idle();
        // R4 subtract forms
        send(4'd8, 0, 16'h0003, 16'h0008, 16'h0000, "R4");
        send(4'd8, 0, 16'h0008, 16'h0003, 16'h0000, "R4");
        send(4'd7, 0, 16'h0003, 16'h0005, 16'h0000, "R4");
        send(4'd8, 0, 16'h0001, 16'h8000, 16'h0000, "R4");
        // R5 compare and bit test
        send(4'd9, 0, 16'h0005, 16'h0005, 16'h0000, "R5");
        send(4'd11, 0, 16'h0008, 16'h000C, 16'h0100, "R5");
        // R6 decimal add
        send(4'd10, 0, 16'h0001, 16'h0199, 16'h0000, "R6");
        send(4'd10, 0, 16'h0001, 16'h9999, 16'h0100, "R6");
        send(4'd10, 0, 16'h4321, 16'h1234, 16'h0001, "R6");
        // R7 bitwise
        send(4'd15, 0, 16'h0F0F, 16'h00FF, 16'h0100, "R7");
        send(4'd12, 0, 16'h0003, 16'h0006, 16'h0005, "R7");
        send(4'd13, 0, 16'h0008, 16'h0004, 16'h0002, "R7");
        send(4'd14, 0, 16'h8000, 16'h8001, 16'h0000, "R7");
        // R8 byte mode with noisy upper bytes
        send(4'd5, 1, 16'h3401, 16'h12FF, 16'h0000, "R8");
        send(4'd8, 1, 16'hAB01, 16'hCD80, 16'h0000, "R8");
        send(4'd10, 1, 16'h5501, 16'h6699, 16'h0000, "R8");
        send(4'd4, 1, 16'hBEEF, 16'h0000, 16'h0000, "R8");
        // R9 untouched status bits
        send(4'd5, 0, 16'h0001, 16'h0001, 16'hFEF8, "R9");
        send(4'd15, 0, 16'h0000, 16'hFFFF, 16'h0A0F, "R9");
        // R10 unused codes
        send(4'd0, 0, 16'h1111, 16'h2222, 16'h0123, "R10");
        send(4'd3, 1, 16'hFFFF, 16'hFFFF, 16'h0F0F, "R10");
        idle();
        // Randomised back-to-back traffic, both widths
        for (int i = 0; i < 300; i++) begin
            ro = 4'($urandom_range(0, 15));
            rs = 16'($urandom);
            rd = 16'($urandom);
            if (ro == 4'd10) begin
                for (int k = 0; k < 4; k++) begin
                    rs[4*k +: 4] = 4'($urandom_range(0, 9));
                    rd[4*k +: 4] = 4'($urandom_range(0, 9));
                end
            end
            send(ro, 1'($urandom), rs, rd, 16'($urandom), "R3/R4/R6/R7/R8 random");
        end
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: got %0d pending items, exp 0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule